// File: doc/BRIEF.md
# Flash Program and Erase Command Controller

This block sits between a processor's register bus and an on-chip flash array and turns register writes into one array command at a time: programming a single 32-bit word, or erasing the page that holds a target address. Software loads an operation code, a target address and a data word. It enables writes and writes a three-value key sequence. It then sets the start bit. The controller keeps the start bit high as a busy flag until the array signals completion or a low-voltage condition aborts the command.

A launch is refused unless write enable is already set and the key sequence has just been written in full and in order. Each unlock allows a single launch. Faults are kept in two sticky flags. One marks a command that hit a locked region or used an unknown code, and the other marks a low-voltage abort. Launching the no-operation code is the only way to clear them. Each register has a plain, a bit-set and a bit-clear write alias, so software can change single bits without a read-modify-write.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, every register reads zero: write enable, busy, both error flags and the operation code are clear, and so are the address and data registers.
- R2: busSel[3:2] picks the register (0 control, 1 key, 2 address, 3 data). busSel[1:0] picks the alias: 1 ORs the written word in, 2 clears the bits that are set in the written word, and 0 or 3 replaces the value. The address and data registers read back the result of that alias.
- R3: Control register layout: operation code in bits 3:0, low-voltage error in bit 12, write error in bit 13, write enable in bit 14, busy/start in bit 15, all other bits read 0. Writes from software never set or clear bits 12, 13 or 15.
- R4: The key register is written with 0x00000000, then 0xAA996655, then 0x556699AA. A control write that then sets bit 15, with write enable already 1, launches the command for code 1 (program) or code 4 (erase). Busy reads 1 and arrReq rises with arrErase, arrAddr and arrData matching the operation.
- R5: A key write whose value is not the next expected value resets the sequence. So does any write to another register in the middle of the sequence. A later start is then ignored: busy stays 0 and no array command is issued.
- R6: A start while write enable is 0 is ignored.
- R7: An unlock permits one launch only. A second start without a new key sequence is ignored.
- R8: Busy stays high until arrDone is seen and clears on the clock after it. When arrLockErr is high with arrDone, the write-error flag (bit 13) is set.
- R9: While busy, writes to the control, address and data registers are ignored, and arrAddr and arrData stay stable.
- R10: When lowVolt is high during a command, the command is aborted: busy and arrReq drop on the next clock and the low-voltage flag (bit 12) is set.
- R11: Launching code 0 clears both error flags and issues no array command. Launching any code other than 0, 1 or 4 sets the write-error flag and issues no array command. In neither case does busy rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busSel | input | 4 | Register select [3:2] and write alias [1:0] |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the register selected by busSel[3:2] (key reads 0) |
| arrReq | output | 1 | Array command active |
| arrErase | output | 1 | 1 = page erase, 0 = word program |
| arrAddr | output | ADDR_W | Target address |
| arrData | output | 32 | Word to program |
| arrDone | input | 1 | Array reports command complete |
| arrLockErr | input | 1 | Array refused a locked target (valid with arrDone) |
| lowVolt | input | 1 | Supply low-voltage indication |

## Verification
The bench builds the block with a 20-bit address and models the array with a 12-cycle completion latency. Addresses at or above 0xC0000 are treated as locked. That latency leaves enough cycles to attempt address, data and control writes, and to raise lowVolt, while a command is still running. The locked upper region produces the write-error path from a plain program request. A scoreboard pairs each array command it expects with the one the array model receives, so a refused launch shows up as an unexpected command.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int WORD_W = 32;
  localparam int OP_W   = 4;

  localparam int BUSY_BIT  = 15;
  localparam int WREN_BIT  = 14;
  localparam int WERR_BIT  = 13;
  localparam int LVERR_BIT = 12;

  localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OP_W-1:0] OP_PROG  = 4'd1;
  localparam logic [OP_W-1:0] OP_ERASE = 4'd4;

  localparam logic [WORD_W-1:0] KEY_A = 32'h0000_0000;
  localparam logic [WORD_W-1:0] KEY_B = 32'hAA99_6655;
  localparam logic [WORD_W-1:0] KEY_C = 32'h5566_99AA;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_KEY  = 2'd1,
    REG_ADDR = 2'd2,
    REG_DATA = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    AL_PLAIN = 2'd0,
    AL_SET   = 2'd1,
    AL_CLR   = 2'd2,
    AL_PLAIN2 = 2'd3
  } alias_e;

  typedef struct packed {
    logic clrErr;
    logic setWerr;
    logic setLverr;
  } ctrlStrobe_t;

  function automatic logic [WORD_W-1:0] applyAlias(input logic [1:0] al,
                                                   input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] wd);
    case (al)
      AL_SET:  return cur | wd;
      AL_CLR:  return cur & ~wd;
      default: return wd;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] keyAt(input logic [1:0] step);
    case (step)
      2'd0:    return KEY_A;
      2'd1:    return KEY_B;
      default: return KEY_C;
    endcase
  endfunction

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [3:0]        busSel,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              wrenQ,
  input  logic [OP_W-1:0]   opQ,
  input  logic              arrDone,
  input  logic              arrLockErr,
  input  logic              lowVolt,
  output logic              busy,
  output logic              arrErase,
  output ctrlStrobe_t       strobes
);

  logic [1:0] keyStep;
  logic       keyWr, otherWr, startReq, unlocked, startOk, opValid;

  assign keyWr    = busWr && (busSel[3:2] == REG_KEY);
  assign otherWr  = busWr && (busSel[3:2] != REG_KEY);
  assign startReq = busWr && (busSel[3:2] == REG_CTRL) &&
                    (busSel[1:0] != AL_CLR) && busWdata[BUSY_BIT];
  assign unlocked = (keyStep == 2'd3);
  assign startOk  = startReq && !busy && wrenQ && unlocked;
  assign opValid  = (opQ == OP_PROG) || (opQ == OP_ERASE);
  assign arrErase = (opQ == OP_ERASE);

  always_comb begin
    strobes.clrErr   = startOk && (opQ == OP_NOP);
    strobes.setWerr  = (startOk && !opValid && (opQ != OP_NOP)) ||
                       (busy && arrDone && arrLockErr && !lowVolt);
    strobes.setLverr = busy && lowVolt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (startOk && opValid) busy <= 1'b1;
    end else if (lowVolt || arrDone) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyStep <= 2'd0;
    end else if (keyWr) begin
      if (!unlocked && (busWdata == keyAt(keyStep))) keyStep <= keyStep + 2'd1;
      else keyStep <= 2'd0;
    end else if (otherWr) begin
      keyStep <= 2'd0;
    end
  end

  // R4
  launch_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(keyStep) == 2'd3);

  // R6
  launch_needs_wren_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrenQ));

  // R7
  unlock_consumed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> keyStep == 2'd0);

  // R8
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !arrDone && !lowVolt |=> busy);

  // R10
  lowvolt_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && lowVolt |=> !busy);

endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [3:0]        busSel,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              busy,
  input  ctrlStrobe_t       strobes,
  output logic [WORD_W-1:0] busRdata,
  output logic              wrenQ,
  output logic [OP_W-1:0]   opQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [WORD_W-1:0] dataQ
);

  localparam int PAD_W = WORD_W - ADDR_W;

  logic              werrQ, lverrQ;
  logic [WORD_W-1:0] ctrlView, addrView, ctrlNext, addrNext, dataNext;
  logic              wrCtrl, wrAddr, wrData;

  assign ctrlView = {16'h0, busy, wrenQ, werrQ, lverrQ, 8'h0, opQ};
  assign addrView = {{PAD_W{1'b0}}, addrQ};

  assign ctrlNext = applyAlias(busSel[1:0], ctrlView, busWdata);
  assign addrNext = applyAlias(busSel[1:0], addrView, busWdata);
  assign dataNext = applyAlias(busSel[1:0], dataQ, busWdata);

  assign wrCtrl = busWr && !busy && (busSel[3:2] == REG_CTRL);
  assign wrAddr = busWr && !busy && (busSel[3:2] == REG_ADDR);
  assign wrData = busWr && !busy && (busSel[3:2] == REG_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= '0;
      wrenQ <= 1'b0;
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (wrCtrl) begin
        opQ   <= ctrlNext[OP_W-1:0];
        wrenQ <= ctrlNext[WREN_BIT];
      end
      if (wrAddr) addrQ <= addrNext[ADDR_W-1:0];
      if (wrData) dataQ <= dataNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      werrQ  <= 1'b0;
      lverrQ <= 1'b0;
    end else if (strobes.clrErr) begin
      werrQ  <= 1'b0;
      lverrQ <= 1'b0;
    end else begin
      if (strobes.setWerr)  werrQ  <= 1'b1;
      if (strobes.setLverr) lverrQ <= 1'b1;
    end
  end

  always_comb begin
    case (busSel[3:2])
      REG_CTRL: busRdata = ctrlView;
      REG_ADDR: busRdata = addrView;
      REG_DATA: busRdata = dataQ;
      default:  busRdata = '0;
    endcase
  end

  // R9
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> $stable(addrQ));

  // R9
  data_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> $stable(dataQ));

  // R3
  wren_from_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrenQ) |-> $past(busWr && busSel[3:2] == REG_CTRL));

  // R10
  lverr_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lverrQ) |-> $past(busy));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [3:0]        busSel,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              arrReq,
  output logic              arrErase,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [31:0]       arrData,
  input  logic              arrDone,
  input  logic              arrLockErr,
  input  logic              lowVolt
);

  logic            busy, wrenQ;
  logic [OP_W-1:0] opQ;
  ctrlStrobe_t     strobes;

  flash_cmd_fsm u_fsm (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel), .busWdata(busWdata),
    .wrenQ(wrenQ), .opQ(opQ), .arrDone(arrDone), .arrLockErr(arrLockErr),
    .lowVolt(lowVolt), .busy(busy), .arrErase(arrErase), .strobes(strobes)
  );

  flash_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel), .busWdata(busWdata),
    .busy(busy), .strobes(strobes), .busRdata(busRdata), .wrenQ(wrenQ),
    .opQ(opQ), .addrQ(arrAddr), .dataQ(arrData)
  );

  assign arrReq = busy;

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

  localparam int ADDR_W = 20;
  localparam int LAT = 12;
  localparam logic [ADDR_W-1:0] LOCK_BASE = 20'hC0000;

  typedef struct packed {
    logic              erase;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
  } cmd_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [3:0] busSel = 4'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic arrReq, arrErase;
  logic [ADDR_W-1:0] arrAddr;
  logic [31:0] arrData;
  logic arrDone = 1'b0;
  logic arrLockErr = 1'b0;
  logic lowVolt = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  cmd_t expQ[$];

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W)) u_flash_cmd_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel), .busWdata(busWdata),
    .busRdata(busRdata), .arrReq(arrReq), .arrErase(arrErase), .arrAddr(arrAddr),
    .arrData(arrData), .arrDone(arrDone), .arrLockErr(arrLockErr), .lowVolt(lowVolt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // array model with fixed latency; locked upper region
  int latCnt = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      latCnt = 0;
      arrDone = 1'b0;
    end else begin
      arrDone = 1'b0;
      if (arrReq) begin
        latCnt++;
        if (latCnt == LAT) begin
          arrDone = 1'b1;
          arrLockErr = (arrAddr >= LOCK_BASE);
          latCnt = 0;
        end
      end else begin
        latCnt = 0;
      end
    end
  end

  // monitor: each new array command is popped and compared
  logic prevReq = 1'b0;
  always @(negedge clk) begin
    if (rstN && arrReq && !prevReq) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R5: actual unexpected array command addr %h expected none", arrAddr);
      end else begin
        cmd_t e;
        e = expQ.pop_front();
        chk("R4 erase", {31'd0, arrErase}, {31'd0, e.erase});
        chk("R4 addr", 32'(arrAddr), 32'(e.addr));
        chk("R4 data", arrData, e.data);
      end
    end
    prevReq = arrReq;
  end

  task automatic busW(input logic [1:0] r, input logic [1:0] al, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1;
    busSel = {r, al};
    busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] r, output logic [31:0] v);
    busSel = {r, 2'd0};
    #1;
    v = busRdata;
  endtask

  task automatic unlock();
    busW(2'd1, 2'd0, 32'h0000_0000);
    busW(2'd1, 2'd0, 32'hAA99_6655);
    busW(2'd1, 2'd0, 32'h5566_99AA);
  endtask

  task automatic expectCmd(input logic er, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    cmd_t c;
    c.erase = er;
    c.addr = a;
    c.data = d;
    expQ.push_back(c);
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(2'd0, v);
      if (!v[15]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd2, v); chk("R1 addr", v, 32'h0);
    rd(2'd3, v); chk("R1 data", v, 32'h0);
    chk("R1 arrReq", {31'd0, arrReq}, 32'd0);

    // R2 aliases on the address register
    busW(2'd2, 2'd0, 32'h0000_1234);
    busW(2'd2, 2'd1, 32'h0003_0000);
    rd(2'd2, v); chk("R2 set alias", v, 32'h0003_1234);
    busW(2'd2, 2'd2, 32'h0000_0030);
    rd(2'd2, v); chk("R2 clear alias", v, 32'h0003_1204);
    busW(2'd3, 2'd0, 32'hDEAD_BEEF);
    rd(2'd3, v); chk("R2 data plain", v, 32'hDEAD_BEEF);

    // R3 error bits not writable, wren and op are
    busW(2'd0, 2'd0, 32'hFFFF_7001);
    rd(2'd0, v); chk("R3 ctrl layout", v, 32'h0000_4001);

    // R4 program launch
    unlock();
    expectCmd(1'b0, 20'h31204, 32'hDEAD_BEEF);
    busW(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R4 busy after start", v, 32'h0000_C001);
    chk("R4 arrReq", {31'd0, arrReq}, 32'd1);
    waitIdle();
    rd(2'd0, v); chk("R8 clean finish", v, 32'h0000_4001);

    // R7 second start without fresh unlock
    busW(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R7 start reused unlock", v, 32'h0000_4001);

    // R6 wren clear
    busW(2'd0, 2'd2, 32'h0000_4000);
    unlock();
    busW(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R6 start without wren", v, 32'h0000_0001);

    // R5 wrong key value
    busW(2'd0, 2'd1, 32'h0000_4000);
    busW(2'd1, 2'd0, 32'h0000_0000);
    busW(2'd1, 2'd0, 32'hAA99_6655);
    busW(2'd1, 2'd0, 32'h1234_5678);
    busW(2'd1, 2'd0, 32'h5566_99AA);
    busW(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R5 wrong key", v, 32'h0000_4001);

    // R5 foreign write between keys
    busW(2'd1, 2'd0, 32'h0000_0000);
    busW(2'd1, 2'd0, 32'hAA99_6655);
    busW(2'd3, 2'd0, 32'hDEAD_BEEF);
    busW(2'd1, 2'd0, 32'h5566_99AA);
    busW(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R5 interleaved write", v, 32'h0000_4001);

    // R9 erase with writes during busy
    busW(2'd0, 2'd0, 32'h0000_4004);
    busW(2'd2, 2'd0, 32'h0002_0000);
    unlock();
    expectCmd(1'b1, 20'h20000, 32'hDEAD_BEEF);
    busW(2'd0, 2'd1, 32'h0000_8000);
    busW(2'd2, 2'd0, 32'h0001_1111);
    busW(2'd3, 2'd0, 32'h0000_0000);
    busW(2'd0, 2'd2, 32'h0000_4000);
    chk("R9 arrAddr stable", 32'(arrAddr), 32'h0002_0000);
    chk("R9 arrData stable", arrData, 32'hDEAD_BEEF);
    waitIdle();
    rd(2'd2, v); chk("R9 addr kept", v, 32'h0002_0000);
    rd(2'd3, v); chk("R9 data kept", v, 32'hDEAD_BEEF);
    rd(2'd0, v); chk("R9 ctrl kept", v, 32'h0000_4004);

    // R8 locked target sets write error
    busW(2'd0, 2'd0, 32'h0000_4001);
    busW(2'd2, 2'd0, 32'h000C_0010);
    unlock();
    expectCmd(1'b0, 20'hC0010, 32'hDEAD_BEEF);
    busW(2'd0, 2'd1, 32'h0000_8000);
    waitIdle();
    rd(2'd0, v); chk("R8 lock error", v, 32'h0000_6001);

    // R11 no-op launch clears errors
    busW(2'd0, 2'd0, 32'h0000_4000);
    unlock();
    busW(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R11 nop clears", v, 32'h0000_4000);

    // R10 low-voltage abort
    busW(2'd0, 2'd0, 32'h0000_4001);
    busW(2'd2, 2'd0, 32'h0000_0100);
    unlock();
    expectCmd(1'b0, 20'h00100, 32'hDEAD_BEEF);
    busW(2'd0, 2'd1, 32'h0000_8000);
    repeat (2) @(negedge clk);
    lowVolt = 1'b1;
    @(negedge clk);
    lowVolt = 1'b0;
    rd(2'd0, v); chk("R10 abort flags", v, 32'h0000_5001);
    chk("R10 arrReq dropped", {31'd0, arrReq}, 32'd0);

    // R11 clears low-voltage flag, unknown code sets write error
    busW(2'd0, 2'd0, 32'h0000_4000);
    unlock();
    busW(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R11 nop clears lverr", v, 32'h0000_4000);
    busW(2'd0, 2'd0, 32'h0000_4002);
    unlock();
    busW(2'd0, 2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R11 unknown code", v, 32'h0000_6002);
    repeat (LAT + 4) @(negedge clk);
    chk("R11 no command", {31'd0, arrReq}, 32'd0);

    chk("R4 all expected commands seen", expQ.size(), 32'd0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule